// File: doc/BRIEF.md
# MESI Line Controller for a Split-Transaction Snooping Bus

This block keeps the coherence state and data of a small, directly indexed set of cache lines. It uses four stable states (invalid, shared, exclusive, modified) on a snooping bus where requests are not atomic. Issuing a request, seeing that request ordered on the bus, and receiving the data for it are three separate events. Each line therefore passes through transient states that record which of those events it still awaits. The eviction states also have to cope with other caches whose requests are ordered before the line's own writeback.

The core presents one request at a time: a load, a store or an evict, together with a line index. The request completes in the cycle `core_ready` is high. A request that misses puts a request on the bus, and the core holds the same request until it completes. The snoop port carries every request in bus order, with a flag that marks the line's own requests. The data port delivers fill data and says whether the fill grants exclusive ownership. The block answers other caches' requests with data for the requestor and, where needed, a copy for memory.

All outputs are combinational functions of the current inputs and the line state. The line state changes on the next rising clock edge. A snoop or a fill that addresses the same line as the core request in the same cycle takes precedence, and the core request waits.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid and no bus request, requestor data or memory writeback is driven while the inputs are idle.
- R2: A load to an invalid line issues a bus request of type 0 (read-shared) and waits. After the own type-0 request is snooped, fill data moves the line to exclusive if the fill is marked exclusive, otherwise to shared. Loads then complete with the filled data.
- R3: A store to an invalid line issues a bus request of type 1 (read-for-ownership). The line becomes modified only after the own type-1 request is snooped and the fill arrives, and the stored value then replaces the fill.
- R4: A store to a shared line issues type 1 and waits, while loads to that line keep completing. If another cache's type-1 request is snooped before the own one, the line continues as a full miss: it still needs its own request to be snooped and then the data.
- R5: A store to an exclusive line completes at once, with no bus request, and leaves the line modified.
- R6: In exclusive or modified, another cache's type-0 request returns the line data to the requestor and to memory and leaves the line shared. Another cache's type-1 request returns the data to the requestor only and invalidates the line.
- R7: Evicting an exclusive or modified line completes and issues type 2 (writeback). When the own type-2 request is snooped, the data goes to memory and the line becomes invalid. Evicting a shared or invalid line completes with no bus activity and leaves the line invalid.
- R8: While its own writeback is pending, a line serves another cache's type-0 request (data to requestor and memory) or type-1 request (data to requestor only). When its own type-2 request is later snooped, the line becomes invalid with no memory write.
- R9: In every transient state core requests stall, except loads in the shared-to-modified states. A line never has more than one bus request outstanding, and a stalled core request never reissues one.
- R10: A shared line invalidates on another cache's type-1 request, so a later load to it misses and issues type 0.
- R11: A snoop or fill that addresses the same line as the core request in the same cycle stalls the core request for that cycle. Core op encodings: 0 load, 1 store, 2 evict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | 0 load, 1 store, 2 evict |
| core_idx | input | IW | Line index of core request |
| core_wdata | input | DW | Store data |
| core_ready | output | 1 | Core request completes this cycle |
| core_rdata | output | DW | Line data for a completing load |
| bus_req_valid | output | 1 | Bus request issued this cycle |
| bus_req_type | output | 2 | 0 read-shared, 1 read-for-ownership, 2 writeback |
| bus_req_idx | output | IW | Line of issued request |
| snoop_valid | input | 1 | Ordered bus request observed |
| snoop_own | input | 1 | Observed request is this cache's own |
| snoop_type | input | 2 | Type of observed request |
| snoop_idx | input | IW | Line of observed request |
| fill_valid | input | 1 | Fill data arriving |
| fill_excl | input | 1 | Fill grants exclusive ownership |
| fill_idx | input | IW | Line of fill |
| fill_data | input | DW | Fill data |
| resp_valid | output | 1 | Data to another requestor |
| resp_data | output | DW | Data for the requestor |
| wb_valid | output | 1 | Data to memory |
| wb_data | output | DW | Data for memory |

## Verification
A wrong internal state shows up at the ports the next time the line is touched. A line left stable when it should be transient answers a load with `core_ready` instead of stalling. A line wrongly transient reissues nothing and stalls a load that should hit. A wrong owner state either drops or adds `resp_valid` and `wb_valid` on the next foreign snoop. A lost fill shows as wrong `core_rdata` on the first completing load. The reference model compares every output on every cycle, so such a divergence is reported no later than the first cycle in which the affected line is addressed again.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int NLINES = 4,
  parameter int DW = 8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_valid,
  input  logic [1:0]    core_op,
  input  logic [IW-1:0] core_idx,
  input  logic [DW-1:0] core_wdata,
  output logic          core_ready,
  output logic [DW-1:0] core_rdata,
  output logic          bus_req_valid,
  output logic [1:0]    bus_req_type,
  output logic [IW-1:0] bus_req_idx,
  input  logic          snoop_valid,
  input  logic          snoop_own,
  input  logic [1:0]    snoop_type,
  input  logic [IW-1:0] snoop_idx,
  input  logic          fill_valid,
  input  logic          fill_excl,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          wb_valid,
  output logic [DW-1:0] wb_data
);

  typedef enum logic [3:0] {
    ST_I, ST_S, ST_E, ST_M, ST_ISAD, ST_ISD, ST_IMAD, ST_IMD,
    ST_SMAD, ST_SMD, ST_MIA, ST_EIA, ST_IIA
  } st_t;

  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_EV = 2'd2;
  localparam logic [1:0] RQ_RD = 2'd0, RQ_OWN = 2'd1, RQ_WB = 2'd2;

  st_t           st  [NLINES];
  logic [DW-1:0] dat [NLINES];
  logic [NLINES-1:0] pend;

  st_t cst, sst, fst, cnext, snext, fnext;
  logic hit, issue, cwr, cupd, supd, blk, core_go;
  logic [1:0] rtype;

  assign cst = st[core_idx];
  assign sst = st[snoop_idx];
  assign fst = st[fill_idx];
  assign blk = (snoop_valid && snoop_idx == core_idx) || (fill_valid && fill_idx == core_idx);
  assign core_go = core_valid && !blk;

  always_comb begin
    hit = 1'b0; issue = 1'b0; cwr = 1'b0; cupd = 1'b0; rtype = RQ_RD; cnext = cst;
    case (core_op)
      OP_LD: begin
        if (cst inside {ST_S, ST_E, ST_M, ST_SMAD, ST_SMD}) hit = 1'b1;
        else if (cst == ST_I) begin issue = 1'b1; rtype = RQ_RD; cnext = ST_ISAD; cupd = 1'b1; end
      end
      OP_ST: begin
        if (cst == ST_M) begin hit = 1'b1; cwr = 1'b1; end
        else if (cst == ST_E) begin hit = 1'b1; cwr = 1'b1; cnext = ST_M; cupd = 1'b1; end
        else if (cst == ST_I) begin issue = 1'b1; rtype = RQ_OWN; cnext = ST_IMAD; cupd = 1'b1; end
        else if (cst == ST_S) begin issue = 1'b1; rtype = RQ_OWN; cnext = ST_SMAD; cupd = 1'b1; end
      end
      OP_EV: begin
        if (cst == ST_I) hit = 1'b1;
        else if (cst == ST_S) begin hit = 1'b1; cnext = ST_I; cupd = 1'b1; end
        else if (cst == ST_E) begin hit = 1'b1; issue = 1'b1; rtype = RQ_WB; cnext = ST_EIA; cupd = 1'b1; end
        else if (cst == ST_M) begin hit = 1'b1; issue = 1'b1; rtype = RQ_WB; cnext = ST_MIA; cupd = 1'b1; end
      end
      default: ;
    endcase
    if (issue && pend[core_idx]) begin issue = 1'b0; cupd = 1'b0; hit = 1'b0; end
  end

  assign core_ready    = core_go && hit;
  assign core_rdata    = dat[core_idx];
  assign bus_req_valid = core_go && issue;
  assign bus_req_type  = rtype;
  assign bus_req_idx   = core_idx;

  always_comb begin
    snext = sst; supd = 1'b0; resp_valid = 1'b0; wb_valid = 1'b0;
    if (snoop_valid && snoop_own) begin
      case (sst)
        ST_ISAD: if (snoop_type == RQ_RD)  begin snext = ST_ISD; supd = 1'b1; end
        ST_IMAD: if (snoop_type == RQ_OWN) begin snext = ST_IMD; supd = 1'b1; end
        ST_SMAD: if (snoop_type == RQ_OWN) begin snext = ST_SMD; supd = 1'b1; end
        ST_MIA, ST_EIA: if (snoop_type == RQ_WB) begin snext = ST_I; supd = 1'b1; wb_valid = 1'b1; end
        ST_IIA: if (snoop_type == RQ_WB) begin snext = ST_I; supd = 1'b1; end
        default: ;
      endcase
    end else if (snoop_valid) begin
      case (sst)
        ST_S:    if (snoop_type == RQ_OWN) begin snext = ST_I; supd = 1'b1; end
        ST_SMAD: if (snoop_type == RQ_OWN) begin snext = ST_IMAD; supd = 1'b1; end
        ST_E, ST_M: begin
          if (snoop_type == RQ_RD) begin snext = ST_S; supd = 1'b1; resp_valid = 1'b1; wb_valid = 1'b1; end
          else if (snoop_type == RQ_OWN) begin snext = ST_I; supd = 1'b1; resp_valid = 1'b1; end
        end
        ST_MIA, ST_EIA: begin
          if (snoop_type == RQ_RD) begin snext = ST_IIA; supd = 1'b1; resp_valid = 1'b1; wb_valid = 1'b1; end
          else if (snoop_type == RQ_OWN) begin snext = ST_IIA; supd = 1'b1; resp_valid = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  assign resp_data = dat[snoop_idx];
  assign wb_data   = dat[snoop_idx];

  always_comb begin
    fnext = fst;
    case (fst)
      ST_ISD:         fnext = fill_excl ? ST_E : ST_S;
      ST_IMD, ST_SMD: fnext = ST_M;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    st_t nst;
    always_comb begin
      nst = st[i];
      if (core_go && cupd && core_idx == IW'(i)) nst = cnext;
      if (supd && snoop_idx == IW'(i)) nst = snext;
      if (fill_valid && fill_idx == IW'(i) && fnext != fst) nst = fnext;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[i] <= ST_I;
        dat[i] <= '0;
        pend[i] <= 1'b0;
      end else begin
        st[i] <= nst;
        if (bus_req_valid && core_idx == IW'(i)) pend[i] <= 1'b1;
        else if (nst inside {ST_I, ST_S, ST_E, ST_M}) pend[i] <= 1'b0;
        if (fill_valid && fill_idx == IW'(i) && fnext != fst) dat[i] <= fill_data;
        else if (core_go && cwr && core_idx == IW'(i)) dat[i] <= core_wdata;
      end
    end
  end

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |=> pend[$past(core_idx)]);
  // R9
  transient_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready && !(cst inside {ST_I, ST_S, ST_E, ST_M})) |-> (core_op == OP_LD));
  // R5
  silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready && core_op == OP_ST && cst == ST_E) |-> !bus_req_valid);
  // R6
  wb_only_on_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || resp_valid) |-> (snoop_valid && !blk_core_wr()));
  // R8
  lost_owner_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_own && sst == ST_IIA) |-> !wb_valid);

  function automatic logic blk_core_wr();
    return core_go && cwr && core_idx == snoop_idx;
  endfunction

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  localparam int CLK = 10;
  localparam int N = 4;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic core_valid = 0; logic [1:0] core_op = 0; logic [1:0] core_idx = 0; logic [DW-1:0] core_wdata = 0;
  logic core_ready; logic [DW-1:0] core_rdata;
  logic bus_req_valid; logic [1:0] bus_req_type; logic [1:0] bus_req_idx;
  logic snoop_valid = 0, snoop_own = 0; logic [1:0] snoop_type = 0; logic [1:0] snoop_idx = 0;
  logic fill_valid = 0, fill_excl = 0; logic [1:0] fill_idx = 0; logic [DW-1:0] fill_data = 0;
  logic resp_valid; logic [DW-1:0] resp_data; logic wb_valid; logic [DW-1:0] wb_data;

  mesi_line_ctrl #(.NLINES(N), .DW(DW)) uut (.*);

  always #(CLK/2) clk = ~clk;

  // reference model: line state as text, data as integers
  string ms [N];
  int    md [N];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit transient(string s);
    return !(s == "I" || s == "S" || s == "E" || s == "M");
  endfunction

  task automatic step(string tag);
    int er = 0, eb = 0, et = 0, ers = 0, ewb = 0;
    string ns_c, ns_s;
    bit blk, cw, cu, su;
    @(negedge clk);
    blk = (snoop_valid && snoop_idx == core_idx) || (fill_valid && fill_idx == core_idx);
    cw = 0; cu = 0; su = 0; ns_c = ms[core_idx]; ns_s = ms[snoop_idx];
    if (core_valid && !blk) begin
      string s = ms[core_idx];
      if (core_op == 0) begin
        if (s == "S" || s == "E" || s == "M" || s == "SMAD" || s == "SMD") er = 1;
        else if (s == "I") begin eb = 1; et = 0; ns_c = "ISAD"; cu = 1; end
      end else if (core_op == 1) begin
        if (s == "M") begin er = 1; cw = 1; end
        else if (s == "E") begin er = 1; cw = 1; ns_c = "M"; cu = 1; end
        else if (s == "I") begin eb = 1; et = 1; ns_c = "IMAD"; cu = 1; end
        else if (s == "S") begin eb = 1; et = 1; ns_c = "SMAD"; cu = 1; end
      end else if (core_op == 2) begin
        if (s == "I") er = 1;
        else if (s == "S") begin er = 1; ns_c = "I"; cu = 1; end
        else if (s == "E") begin er = 1; eb = 1; et = 2; ns_c = "EIA"; cu = 1; end
        else if (s == "M") begin er = 1; eb = 1; et = 2; ns_c = "MIA"; cu = 1; end
      end
    end
    if (snoop_valid) begin
      string s = ms[snoop_idx];
      if (snoop_own) begin
        if (s == "ISAD" && snoop_type == 0) begin ns_s = "ISD"; su = 1; end
        if (s == "IMAD" && snoop_type == 1) begin ns_s = "IMD"; su = 1; end
        if (s == "SMAD" && snoop_type == 1) begin ns_s = "SMD"; su = 1; end
        if ((s == "MIA" || s == "EIA") && snoop_type == 2) begin ns_s = "I"; su = 1; ewb = 1; end
        if (s == "IIA" && snoop_type == 2) begin ns_s = "I"; su = 1; end
      end else begin
        if (s == "S" && snoop_type == 1) begin ns_s = "I"; su = 1; end
        if (s == "SMAD" && snoop_type == 1) begin ns_s = "IMAD"; su = 1; end
        if (s == "E" || s == "M") begin
          if (snoop_type == 0) begin ns_s = "S"; su = 1; ers = 1; ewb = 1; end
          if (snoop_type == 1) begin ns_s = "I"; su = 1; ers = 1; end
        end
        if (s == "MIA" || s == "EIA") begin
          if (snoop_type == 0) begin ns_s = "IIA"; su = 1; ers = 1; ewb = 1; end
          if (snoop_type == 1) begin ns_s = "IIA"; su = 1; ers = 1; end
        end
      end
    end
    chk(tag, "core_ready", core_ready, er);
    if (er && core_op == 0) chk(tag, "core_rdata", core_rdata, md[core_idx]);
    chk(tag, "bus_req_valid", bus_req_valid, eb);
    if (eb) begin chk(tag, "bus_req_type", bus_req_type, et); chk(tag, "bus_req_idx", bus_req_idx, core_idx); end
    chk(tag, "resp_valid", resp_valid, ers);
    if (ers) chk(tag, "resp_data", resp_data, md[snoop_idx]);
    chk(tag, "wb_valid", wb_valid, ewb);
    if (ewb) chk(tag, "wb_data", wb_data, md[snoop_idx]);
    if (cu) ms[core_idx] = ns_c;
    if (cw) md[core_idx] = core_wdata;
    if (su) ms[snoop_idx] = ns_s;
    if (fill_valid) begin
      string s = ms[fill_idx];
      if (s == "ISD") begin ms[fill_idx] = fill_excl ? "E" : "S"; md[fill_idx] = fill_data; end
      else if (s == "IMD" || s == "SMD") begin ms[fill_idx] = "M"; md[fill_idx] = fill_data; end
    end
    @(posedge clk); #1;
  endtask

  task automatic idle();
    core_valid = 0; snoop_valid = 0; fill_valid = 0;
  endtask
  task automatic core(string tag, int op, int idx, int wd);
    idle(); core_valid = 1; core_op = 2'(op); core_idx = 2'(idx); core_wdata = DW'(wd); step(tag);
  endtask
  task automatic snp(string tag, bit own, int ty, int idx);
    idle(); snoop_valid = 1; snoop_own = own; snoop_type = 2'(ty); snoop_idx = 2'(idx); step(tag);
  endtask
  task automatic fil(string tag, bit ex, int idx, int d);
    idle(); fill_valid = 1; fill_excl = ex; fill_idx = 2'(idx); fill_data = DW'(d); step(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin ms[i] = "I"; md[i] = 0; end
    repeat (3) @(posedge clk); #1; rst_n = 1;
    idle(); step("R1");
    // R2 exclusive fill, R5 silent upgrade
    core("R2", 0, 0, 0); core("R9", 0, 0, 0);
    snp("R2", 1, 0, 0); core("R9", 0, 0, 0);
    fil("R2", 1, 0, 8'h5a); core("R2", 0, 0, 0);
    core("R5", 1, 0, 8'h33); core("R5", 0, 0, 0);
    snp("R6", 0, 0, 0); core("R6", 0, 0, 0);
    // R2 shared fill, R4 upgrade race
    core("R2", 0, 1, 0); snp("R2", 1, 0, 1); fil("R2", 0, 1, 8'h11); core("R2", 0, 1, 0);
    core("R4", 1, 1, 8'h22); core("R4", 0, 1, 0); core("R9", 1, 1, 8'h22);
    snp("R4", 0, 1, 1); core("R4", 0, 1, 0);
    snp("R4", 1, 1, 1); fil("R4", 0, 1, 8'h44); core("R4", 1, 1, 8'h45); core("R4", 0, 1, 0);
    // R3 store miss, R8 writeback race with GetM
    core("R3", 1, 2, 8'h77); core("R9", 1, 2, 8'h77);
    snp("R3", 1, 1, 2); core("R9", 1, 2, 8'h77);
    fil("R3", 0, 2, 8'h66); core("R3", 1, 2, 8'h77); core("R3", 0, 2, 0);
    core("R7", 2, 2, 0); core("R9", 0, 2, 0);
    snp("R8", 0, 1, 2); snp("R8", 1, 2, 2); core("R8", 0, 2, 0);
    // R7 evict exclusive
    core("R7", 0, 3, 0); snp("R7", 1, 0, 3); fil("R7", 1, 3, 8'h99);
    core("R7", 2, 3, 0); snp("R7", 1, 2, 3); core("R7", 0, 3, 0);
    // R8 writeback race with GetS
    core("R7", 1, 1, 8'hab); core("R7", 2, 1, 0);
    snp("R8", 0, 0, 1); snp("R8", 1, 2, 1); core("R8", 2, 1, 0);
    // R10 shared invalidated, R6 GetM on E
    core("R10", 0, 0, 0); snp("R10", 0, 1, 0); core("R10", 0, 0, 0);
    snp("R10", 1, 0, 0); fil("R10", 1, 0, 8'hc3); snp("R6", 0, 1, 0); core("R6", 0, 0, 0);
    // R7 silent evict of shared, R11 same-index collision
    core("R7", 0, 3, 0); snp("R7", 1, 0, 3); fil("R7", 0, 3, 8'h12);
    idle(); core_valid = 1; core_op = 0; core_idx = 3; snoop_valid = 1; snoop_own = 0; snoop_type = 0; snoop_idx = 3; step("R11");
    idle(); core_valid = 1; core_op = 0; core_idx = 3; fill_valid = 1; fill_excl = 0; fill_idx = 2; step("R11");
    core("R7", 2, 3, 0); core("R7", 0, 3, 0);
    idle(); step("R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule